// File: doc/BRIEF.md
# Bus Reset Pulse Generator

This block drives a single active-low reset line for devices sharing a system bus. At power-up the line is held low, and it stays low until the power-good input has been high for a programmable minimum interval, nominally one millisecond. Software can also force a fresh reset pulse of the same minimum width. It does so by writing a control word in which the hard-reset bit is set.

All timing is derived from a free-running timebase clock. The hold interval is given in microseconds together with the timebase frequency, and the block converts them into a cycle count N. N is the product divided by one million, rounded up. With the default 33 MHz timebase and 1000 µs, N is 33000.

A falling power-good pulls the reset line low at once, with no clock edge needed. Release always happens on a timebase edge. Other logic that consumes the line must cross it into its own clock domain.

Top module: `bus_rst_gen`

## Requirements
- R1: While `pg_in` is 0, `bus_rst_n` is 0. A falling `pg_in` drives `bus_rst_n` to 0 at once, without waiting for a `clk` edge.
- R2: After `pg_in` rises and stays high, `bus_rst_n` stays 0 through timebase edge SYNC_STAGES+N after the rise and becomes 1 on edge SYNC_STAGES+N+1. The default SYNC_STAGES is 2. N = ceil(CLK_HZ*HOLD_US/1e6).
- R3: A write has `ctl_wr`=1 and bit HARD_BIT of `ctl_wdata` equal to 1. When such a write is sampled on edge k while `pg_in` is high, `bus_rst_n` is 0 from edge k through edge k+N and returns to 1 on edge k+N+1.
- R4: A write whose bit HARD_BIT is 0, or data with bit HARD_BIT set while `ctl_wr` is 0, leaves `bus_rst_n` unchanged.
- R5: A hard-reset write that arrives while a pulse is active restarts the interval. Release then happens N+1 edges after the latest request, not after the earlier one.
- R6: If `pg_in` falls during the release count, the count restarts. Release follows R2, timed from the last rising edge of `pg_in`.
- R7: Once `bus_rst_n` is 1 and `pg_in` stays high, `bus_rst_n` stays 1 until a hard-reset write occurs.
- R8: A hard-reset write made while `pg_in` is 0 has no effect on the release timing after `pg_in` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase clock |
| pg_in | input | 1 | Power-good, active high, asynchronous |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | DATA_W | Control register write data |
| bus_rst_n | output | 1 | Active-low bus reset output |

## Verification
The power-up pattern measures the release edge against N. A second pattern drops power-good partway through the count and shows whether the count truly restarts, rather than carrying on from where it was. Single software requests confirm the pulse width. A second request issued mid-pulse distinguishes a restarted interval from one that ends on the first request's schedule. Writes with only the neighbouring data bits set, data without the strobe, and requests made while power-good is low all show that only the decoded bit under a live power-good starts a pulse.

// File: rtl/bus_rst_pkg.sv
package bus_rst_pkg;

  // Cycles needed to cover hold_us microseconds at clk_hz, rounded up.
  function automatic int unsigned hold_cycles(input int unsigned clk_hz,
                                              input int unsigned hold_us);
    longint unsigned prod;
    prod = 64'(clk_hz) * 64'(hold_us);
    return 32'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

  // Bits needed to hold the value n.
  function automatic int unsigned count_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/bus_rst_pg_sync.sv
module bus_rst_pg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic pg_in,
  output logic pg_ok
);
  logic [STAGES-1:0] shift_q;

  // Clears at once on power-good loss, fills with ones on clk after it returns.
  always_ff @(posedge clk or negedge pg_in) begin
    if (!pg_in) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign pg_ok = shift_q[STAGES-1];
endmodule

// File: rtl/bus_rst_req_decode.sv
module bus_rst_req_decode #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HARD_BIT = 0
) (
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_wdata,
  input  logic              pg_ok,
  output logic              hard_req
);
  // The request bit is write-only and clears itself: nothing is stored.
  assign hard_req = ctl_wr & ctl_wdata[HARD_BIT] & pg_ok;
endmodule

// File: rtl/bus_rst_hold_timer.sv
module bus_rst_hold_timer #(
  parameter int unsigned HOLD_N = 1,
  parameter int unsigned CNT_W  = 1
) (
  input  logic clk,
  input  logic pg_in,
  input  logic pg_ok,
  input  logic restart,
  output logic expired
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_N);

  logic [CNT_W-1:0] cnt_q;

  // Held at the full interval until power-good is confirmed; reloaded by a request.
  always_ff @(posedge clk or negedge pg_in) begin
    if (!pg_in)                  cnt_q <= LOAD;
    else if (!pg_ok || restart)  cnt_q <= LOAD;
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/bus_rst_gen.sv
module bus_rst_gen #(
  parameter int unsigned CLK_HZ      = 33_000_000,
  parameter int unsigned HOLD_US     = 1000,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned HARD_BIT    = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              pg_in,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic              bus_rst_n
);
  localparam int unsigned HOLD_N = bus_rst_pkg::hold_cycles(CLK_HZ, HOLD_US);
  localparam int unsigned CNT_W  = bus_rst_pkg::count_bits(HOLD_N);

  // Named internal events, visible to the bound checker.
  logic pg_ok;
  logic hard_req;
  logic expired;
  logic rst_n_q;

  bus_rst_pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .pg_in (pg_in),
    .pg_ok (pg_ok)
  );

  bus_rst_req_decode #(.DATA_W(DATA_W), .HARD_BIT(HARD_BIT)) u_dec (
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .pg_ok     (pg_ok),
    .hard_req  (hard_req)
  );

  bus_rst_hold_timer #(.HOLD_N(HOLD_N), .CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .pg_in   (pg_in),
    .pg_ok   (pg_ok),
    .restart (hard_req),
    .expired (expired)
  );

  // Asserted asynchronously by power loss; released only on a timebase edge.
  always_ff @(posedge clk or negedge pg_in) begin
    if (!pg_in) rst_n_q <= 1'b0;
    else        rst_n_q <= pg_ok & expired & ~hard_req;
  end

  assign bus_rst_n = rst_n_q;
endmodule

// File: rtl/bus_rst_gen_chk.sv
module bus_rst_gen_chk #(
  parameter int unsigned HOLD_N = 1
) (
  input logic clk,
  input logic pg_in,
  input logic hard_req,
  input logic bus_rst_n
);
  // Length of the current low stretch, saturating just past the window.
  int unsigned low_run = 0;
  always_ff @(posedge clk) begin
    if (bus_rst_n)                low_run <= 0;
    else if (low_run < HOLD_N + 8) low_run <= low_run + 1;
  end

  p_low_without_pg_r1: assert property (@(posedge clk)
    !pg_in |-> !bus_rst_n)
    else $error("bus reset high while power-good low");

  p_req_forces_low_r3: assert property (@(posedge clk) disable iff (!pg_in)
    hard_req |=> !bus_rst_n)
    else $error("hard reset request did not pull the line low");

  p_min_low_width_r5: assert property (@(posedge clk) disable iff (!pg_in)
    $rose(bus_rst_n) |-> (low_run >= HOLD_N))
    else $error("reset released before the minimum hold");

  p_hold_high_r7: assert property (@(posedge clk) disable iff (!pg_in)
    (bus_rst_n && !hard_req) |=> bus_rst_n)
    else $error("reset reasserted without a cause");
endmodule

bind bus_rst_gen bus_rst_gen_chk #(.HOLD_N(HOLD_N)) u_chk (
  .clk       (clk),
  .pg_in     (pg_in),
  .hard_req  (hard_req),
  .bus_rst_n (bus_rst_n)
);

// File: tb/bus_rst_gen_tb.sv
module bus_rst_gen_tb;
  localparam int unsigned TB_CLK_HZ  = 40_000;
  localparam int unsigned TB_HOLD_US = 1000;
  localparam int unsigned DW         = 8;
  localparam int unsigned HB         = 2;
  localparam int unsigned SYNC       = 2;
  // Hold cycles restated as whole-cycle ceiling: 40 at this timebase.
  localparam int unsigned N = (TB_CLK_HZ / 1000 * TB_HOLD_US + 999) / 1000;

  logic          clk = 1'b0;
  logic          pg_in = 1'b1;
  logic          ctl_wr = 1'b0;
  logic [DW-1:0] ctl_wdata = '0;
  logic          bus_rst_n;

  always #10 clk = ~clk;

  bus_rst_gen #(.CLK_HZ(TB_CLK_HZ), .HOLD_US(TB_HOLD_US), .DATA_W(DW),
                .HARD_BIT(HB), .SYNC_STAGES(SYNC)) u_dut (
    .clk       (clk),
    .pg_in     (pg_in),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .bus_rst_n (bus_rst_n)
  );

  int unsigned ecnt = 0;
  always @(posedge clk) ecnt++;

  typedef struct {
    int unsigned edge_no;
    logic        val;
    string       tag;
  } exp_t;
  exp_t q[$];

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: bus_rst_n=%0b expected %0b", tag, act, exp);
    end
  endtask

  // Driver side: expectations kept ordered by edge number.
  task automatic expect_at(input int unsigned e, input logic v, input string tag);
    exp_t it;
    int   pos;
    it.edge_no = e;
    it.val     = v;
    it.tag     = tag;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].edge_no > e) begin
        pos = i;
        break;
      end
    end
    q.insert(pos, it);
  endtask

  // Monitor side: compares half a period after each edge.
  always @(negedge clk) begin
    exp_t it;
    while (q.size() > 0 && q[0].edge_no <= ecnt) begin
      it = q.pop_front();
      if (it.edge_no < ecnt) begin
        total++;
        bad++;
        $display("FAIL %s: check at edge %0d missed, now %0d expected %0d",
                 it.tag, it.edge_no, ecnt, it.edge_no);
      end else begin
        chk(it.tag, bus_rst_n, it.val);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wait_drain();
    while (q.size() > 0) step();
  endtask

  // Raises power-good; returns the last edge before the rise.
  task automatic pg_up(input bit with_exp, input string tag, output int unsigned e0);
    step();
    pg_in = 1'b1;
    e0 = ecnt;
    if (with_exp) begin
      expect_at(e0 + SYNC + N, 1'b0, tag);
      expect_at(e0 + SYNC + N + 1, 1'b1, tag);
    end
  endtask

  task automatic pg_down(input string tag);
    step();
    pg_in = 1'b0;
    #1;
    chk(tag, bus_rst_n, 1'b0);
  endtask

  // Puts a write on the bus; k is the edge that samples it.
  task automatic wr_begin(input logic [DW-1:0] data, output int unsigned k);
    step();
    ctl_wr = 1'b1;
    ctl_wdata = data;
    k = ecnt + 1;
  endtask

  task automatic wr_end();
    step();
    ctl_wr = 1'b0;
    ctl_wdata = '0;
  endtask

  localparam logic [DW-1:0] REQ = DW'(1) << HB;

  initial begin
    int unsigned k;
    int unsigned k2;
    int unsigned e0;
    int unsigned e1;

    #1 pg_in = 1'b0;
    #3 chk("R1 reset state", bus_rst_n, 1'b0);
    repeat (3) step();
    expect_at(ecnt + 2, 1'b0, "R1 held low");

    // R8: request while power-good low is forgotten.
    wr_begin(REQ, k);
    wr_end();
    repeat (2) step();
    pg_up(1'b1, "R2 R8 power-up release", e0);
    wait_drain();
    expect_at(ecnt + 5, 1'b1, "R7 stays high");
    wait_drain();

    // R3: single request.
    wr_begin(REQ, k);
    expect_at(k, 1'b0, "R3 pulse start");
    expect_at(k + N, 1'b0, "R3 pulse last low");
    expect_at(k + N + 1, 1'b1, "R3 pulse release");
    wr_end();
    wait_drain();

    // R4: other bits written, and request bit without strobe.
    wr_begin(~REQ, k);
    expect_at(k, 1'b1, "R4 other bits");
    expect_at(k + 3, 1'b1, "R4 other bits later");
    wr_end();
    wait_drain();
    step();
    ctl_wdata = REQ;
    k = ecnt + 1;
    expect_at(k, 1'b1, "R4 no strobe");
    expect_at(k + 2, 1'b1, "R4 no strobe later");
    step();
    step();
    ctl_wdata = '0;
    wait_drain();

    // R5: second request mid-pulse.
    wr_begin(REQ, k);
    expect_at(k, 1'b0, "R5 first request");
    wr_end();
    repeat (15) step();
    wr_begin(REQ, k2);
    expect_at(k + N + 1, 1'b0, "R5 not released on first schedule");
    expect_at(k2 + N, 1'b0, "R5 extended last low");
    expect_at(k2 + N + 1, 1'b1, "R5 extended release");
    wr_end();
    wait_drain();

    // R1 + R6: power loss while high, then a glitch during the count.
    pg_down("R1 async assert from high");
    repeat (3) step();
    pg_up(1'b0, "", e0);
    repeat (10) step();
    pg_down("R1 async assert during count");
    repeat (3) step();
    pg_up(1'b1, "R6 restarted count", e1);
    expect_at(e0 + SYNC + N + 1, 1'b0, "R6 no release on old count");
    wait_drain();

    // R1: power loss in the middle of a software pulse.
    wr_begin(REQ, k);
    wr_end();
    repeat (5) step();
    pg_down("R1 async assert during pulse");
    repeat (2) step();
    pg_up(1'b1, "R6 release after pulse loss", e0);
    wait_drain();
    expect_at(ecnt + 4, 1'b1, "R7 high at end");
    wait_drain();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run not finished, done=%0b expected 1", done);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule